// File: doc/BRIEF.md
# SPI Memory Slave Serial Front-End

This block is the serial edge of a memory device that answers on an SPI bus in mode 0 or mode 3. It oversamples the bus clock, chip select, data input and pause input in the system clock domain. It assembles received bits into bytes, most significant bit first, and hands each byte to a command layer with a one-cycle strobe. It shifts read data out on falling bus-clock edges, drawing each new byte from the command layer at a byte boundary. It also drives the enable that tri-states the serial output.

Chip select acts on edges as well as on levels. After reset no frame can begin until chip select has been seen high and then falling, so a select line that is already low at reset is ignored. The pause input freezes the shifter at its bit position and releases it later. Raising chip select during a pause aborts the frame. Every frame ends with a one-cycle pulse and a flag that says whether the frame held only whole bytes, which the command layer uses to decide whether to start an internal write.

The system clock must run at least four times faster than the bus clock. Power-on detection is represented by the reset input.

Top module: `spi_mem_slave_front`

## Requirements
- R1: The data input is sampled on rising bus-clock edges inside a frame, most significant bit first. After every eighth sample, `rx_valid` is high for exactly one system clock with the assembled byte on `rx_byte`.
- R2: When `tx_en` is high at the first falling bus-clock edge after a completed byte, `tx_data` is loaded. Its bits appear on `spi_miso` from bit 7 down to bit 0, one per falling edge.
- R3: Mode 0 (clock idles low) and mode 3 (clock idles high) give the same received bytes, transmitted bits and frame results.
- R4: After reset, all bus activity is ignored until chip select has been observed high and then falling. A select that is low at reset starts no frame, produces no byte strobes and produces no frame-end pulse.
- R5: A pause begins when, inside a frame, `spi_hold_n` is low while the synchronized bus clock is low. It ends when `spi_hold_n` is high while the clock is low. During a pause, clock and data edges are ignored, and shifting resumes at the same bit position.
- R6: `spi_miso_oe` is high only inside a frame, outside a pause, and after a byte has been loaded with `tx_en` high. It is low whenever chip select is high.
- R7: Raising chip select inside a frame gives a one-cycle `frame_end` pulse. `frame_whole` is 1 only if at least one byte was received, the bit count is on a byte boundary and no pause is active. A frame with a partial last byte, or with no bits at all, gives 0.
- R8: Raising chip select during a pause aborts the frame: `frame_end` pulses with `frame_whole` 0, and the next frame starts at bit 0.
- R9: A frame that ends part-way through a byte leaves no residue. The first byte of the next frame is assembled from its own first eight bits.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, stands for power-on detection |
| spi_sck | input | 1 | Bus serial clock |
| spi_cs_n | input | 1 | Bus chip select, active low |
| spi_mosi | input | 1 | Bus serial data into the slave |
| spi_hold_n | input | 1 | Pause input, active low |
| spi_miso | output | 1 | Serial data out of the slave (meaningful when enabled) |
| spi_miso_oe | output | 1 | Output-drive enable for the serial data pad |
| tx_en | input | 1 | Command layer requests read data at the next byte boundary |
| tx_data | input | 8 | Byte to transmit, loaded at a byte boundary |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_byte | output | 8 | Last received byte |
| frame_end | output | 1 | One-cycle pulse when a frame closes |
| frame_whole | output | 1 | Frame closed on whole bytes, valid with frame_end |

## Verification
The bench goes after the power-up case where select is already low: a design that arms on level rather than edge would strobe bytes from a frame that never legally began. It pauses in the middle of a read byte and toggles clock and data during the pause. A design that did not gate edges would corrupt both the received and transmitted byte, and one that cleared state on the pause would lose the bit position. It aborts a frame during a pause that sits on a byte boundary, where a design that ignored the pause would report a whole frame and commit a write. It also ends frames with one to seven stray bits, where a design that failed to clear its bit count would misalign the next frame's first byte.

// File: rtl/spimf_pkg.sv
package spimf_pkg;
  localparam int BYTE_BITS = 8;
  localparam int POS_W     = $clog2(BYTE_BITS);

  typedef logic [POS_W-1:0]     bitpos_t;
  typedef logic [BYTE_BITS-1:0] byte_t;

  // Next bit position, wrapping at the byte length.
  function automatic bitpos_t pos_next(input bitpos_t p);
    return (p == bitpos_t'(BYTE_BITS - 1)) ? '0 : p + 1'b1;
  endfunction

  // True when the sample at this position completes a byte.
  function automatic logic pos_last(input bitpos_t p);
    return p == bitpos_t'(BYTE_BITS - 1);
  endfunction

  // Whole-byte frame rule used at frame close.
  function automatic logic frame_is_whole(input bitpos_t p, input logic any_byte,
                                          input logic held);
    return any_byte && (p == '0) && !held;
  endfunction
endpackage

// File: rtl/spimf_sync.sv
module spimf_sync #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage <= {STAGES{RST_VAL}};
    else        stage <= {stage[STAGES-2:0], d};
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spimf_frame.sv
module spimf_frame (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic cs_s,
  input  logic hold_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic frame_start,
  output logic frame_stop,
  output logic in_frame,
  output logic hold_q
);
  logic sck_q, cs_q, live;
  logic cs_fall, cs_rise;

  // cs_q resets low, so a select already low at reset yields no falling edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
    end
  end

  assign cs_fall = cs_q & ~cs_s;
  assign cs_rise = ~cs_q & cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       in_frame <= 1'b0;
    else if (cs_fall) in_frame <= 1'b1;
    else if (cs_rise) in_frame <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            hold_q <= 1'b0;
    else if (!in_frame || cs_rise)         hold_q <= 1'b0;
    else if (!hold_q && !hold_s && !sck_s) hold_q <= 1'b1;
    else if (hold_q && hold_s && !sck_s)   hold_q <= 1'b0;
  end

  assign live        = in_frame & ~hold_q & ~cs_s;
  assign sck_rise    = live & sck_s & ~sck_q;
  assign sck_fall    = live & ~sck_s & sck_q;
  assign frame_start = cs_fall;
  assign frame_stop  = cs_rise & in_frame;

  a_r5_hold_entry_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> !$past(sck_s));
  a_r4_frame_needs_select_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> !cs_q);
endmodule

// File: rtl/spimf_shifter.sv
module spimf_shifter
  import spimf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    frame_start,
  input  logic    frame_stop,
  input  logic    sck_rise,
  input  logic    sck_fall,
  input  logic    mosi_s,
  input  logic    tx_en,
  input  byte_t   tx_data,
  output logic    rx_valid,
  output byte_t   rx_byte,
  output bitpos_t bit_pos,
  output logic    got_byte,
  output logic    tx_live,
  output logic    miso
);
  byte_t rx_sh, tx_sh;
  byte_t rx_next;

  assign rx_next = {rx_sh[BYTE_BITS-2:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      bit_pos  <= '0;
      got_byte <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (frame_start || frame_stop) begin
        bit_pos  <= '0;
        got_byte <= 1'b0;
        rx_sh    <= '0;
      end else if (sck_rise) begin
        rx_sh   <= rx_next;
        bit_pos <= pos_next(bit_pos);
        if (pos_last(bit_pos)) begin
          rx_valid <= 1'b1;
          rx_byte  <= rx_next;
          got_byte <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      tx_live <= 1'b0;
    end else if (frame_start || frame_stop) begin
      tx_sh   <= '0;
      tx_live <= 1'b0;
    end else if (sck_fall) begin
      if (bit_pos == '0) begin
        tx_sh   <= tx_en ? tx_data : '0;
        tx_live <= tx_en;
      end else begin
        tx_sh <= {tx_sh[BYTE_BITS-2:0], 1'b0};
      end
    end
  end

  assign miso = tx_sh[BYTE_BITS-1];

  a_r1_byte_marks_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (bit_pos == '0) && got_byte);
endmodule

// File: rtl/spi_mem_slave_front.sv
module spi_mem_slave_front
  import spimf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  input  logic       spi_hold_n,
  output logic       spi_miso,
  output logic       spi_miso_oe,
  input  logic       tx_en,
  input  logic [7:0] tx_data,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       frame_end,
  output logic       frame_whole
);
  localparam int NSIG = 4;
  // Reset values: hold_n released, data low, select low, clock low.
  localparam logic [NSIG-1:0] SYNC_RST = 4'b1000;

  logic [NSIG-1:0] raw_in, syn;
  logic sck_s, cs_s, mosi_s, hold_s;
  logic sck_rise, sck_fall, frame_start, frame_stop, in_frame, hold_q;
  logic got_byte, tx_live;
  bitpos_t bit_pos;

  assign raw_in = {spi_hold_n, spi_mosi, spi_cs_n, spi_sck};

  spimf_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn));

  assign sck_s  = syn[0];
  assign cs_s   = syn[1];
  assign mosi_s = syn[2];
  assign hold_s = syn[3];

  spimf_frame u_frame (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cs_s(cs_s), .hold_s(hold_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .frame_start(frame_start),
    .frame_stop(frame_stop), .in_frame(in_frame), .hold_q(hold_q));

  spimf_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_stop(frame_stop),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s), .tx_en(tx_en),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_byte(rx_byte), .bit_pos(bit_pos),
    .got_byte(got_byte), .tx_live(tx_live), .miso(spi_miso));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_end   <= 1'b0;
      frame_whole <= 1'b0;
    end else begin
      frame_end   <= frame_stop;
      frame_whole <= frame_stop && frame_is_whole(bit_pos, got_byte, hold_q);
    end
  end

  assign spi_miso_oe = in_frame & ~hold_q & tx_live;

  a_r1_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r4_strobe_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> in_frame);
  a_r7_end_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);
  a_r7_whole_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && frame_whole) |-> ($past(bit_pos) == '0));
  a_r8_abort_not_whole: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && $past(hold_q)) |-> !frame_whole);
  a_r5_hold_freezes_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && $past(hold_q)) |-> $stable(bit_pos));
  a_r6_oe_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_miso_oe) |-> ($past(sck_fall) || $past(hold_q)));
endmodule

// File: tb/spi_mem_slave_front_tb.sv
module spi_mem_slave_front_tb;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;   // bus half period in system clocks
  localparam int NVEC  = 6;

  typedef struct packed {
    logic       mode;   // 0: clock idles low, 1: clock idles high
    logic [7:0] b0;     // instruction byte
    logic [7:0] tx;     // byte returned by the command layer
    logic [7:0] b1;     // second byte received while transmitting
    logic [2:0] tail;   // stray bits after the two bytes
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'hA5, 8'h3C, 8'h96, 3'd0},
    '{1'b1, 8'h03, 8'hF0, 8'h5A, 3'd0},
    '{1'b0, 8'h81, 8'h01, 8'h7E, 3'd3},
    '{1'b1, 8'hFF, 8'h80, 8'h00, 3'd7},
    '{1'b0, 8'h00, 8'hAA, 8'hC3, 3'd1},
    '{1'b1, 8'h6B, 8'h55, 8'h24, 3'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b0, mosi = 1'b0, hold_n = 1'b1;
  logic tx_en = 1'b0;
  logic [7:0] tx_data = '0;
  logic miso, miso_oe, rx_valid, frame_end, frame_whole;
  logic [7:0] rx_byte;

  int checks = 0, errors = 0;
  int rx_cnt = 0, fe_cnt = 0;
  logic [7:0] rx_last = '0;
  logic fe_whole = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  spi_mem_slave_front u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_hold_n(hold_n), .spi_miso(miso), .spi_miso_oe(miso_oe), .tx_en(tx_en),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .frame_end(frame_end), .frame_whole(frame_whole));

  // Event monitor, sampling a quarter period after each rising edge.
  always begin
    @(posedge clk);
    #(CLK_P/4);
    if (rx_valid) begin rx_cnt++; rx_last = rx_byte; end
    if (frame_end) begin fe_cnt++; fe_whole = frame_whole; end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b, output logic q);
    sck = 1'b0; mosi = b; idle(HALF);
    q = miso;
    sck = 1'b1; idle(HALF);
  endtask

  task automatic bus_byte(input logic [7:0] b, output logic [7:0] q);
    for (int i = 7; i >= 0; i--) bus_bit(b[i], q[i]);
  endtask

  task automatic frame_open(input logic mode);
    sck = mode; idle(HALF);
    cs_n = 1'b0; idle(HALF);
  endtask

  task automatic frame_close(input logic mode);
    if (!mode) sck = 1'b0;
    idle(HALF);
    cs_n = 1'b1; idle(2*HALF);
  endtask

  initial begin : watchdog
    #(CLK_P*150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] q8;
    logic q1;
    int r0, f0;

    // Select already low at reset (R4).
    idle(4);
    rst_n = 1'b1;
    idle(4);
    chk(miso_oe == 1'b0, "R6 oe low after reset", miso_oe, 0);
    chk(rx_cnt == 0 && fe_cnt == 0, "R4 no events after reset", rx_cnt + fe_cnt, 0);
    r0 = rx_cnt;
    bus_byte(8'hFF, q8);
    sck = 1'b0; idle(HALF);
    chk(rx_cnt == r0, "R4 select low at reset ignored", rx_cnt - r0, 0);
    f0 = fe_cnt;
    cs_n = 1'b1; idle(2*HALF);
    chk(fe_cnt == f0, "R4 no frame end without frame", fe_cnt - f0, 0);

    // Vector table (R1 R2 R3 R6 R7 R9).
    for (int v = 0; v < NVEC; v++) begin
      frame_open(VECS[v].mode);
      r0 = rx_cnt;
      bus_byte(VECS[v].b0, q8);
      chk(rx_cnt == r0 + 1 && rx_last == VECS[v].b0, "R1 R3 R9 first byte",
          rx_last, VECS[v].b0);
      tx_en = 1'b1; tx_data = VECS[v].tx;
      r0 = rx_cnt;
      bus_byte(VECS[v].b1, q8);
      chk(rx_cnt == r0 + 1 && rx_last == VECS[v].b1, "R1 second byte",
          rx_last, VECS[v].b1);
      chk(q8 == VECS[v].tx, "R2 R3 transmitted byte", q8, VECS[v].tx);
      chk(miso_oe == 1'b1, "R6 oe during read", miso_oe, 1);
      for (int t = 0; t < int'(VECS[v].tail); t++) bus_bit(1'b1, q1);
      f0 = fe_cnt;
      frame_close(VECS[v].mode);
      chk(fe_cnt == f0 + 1, "R7 one frame end", fe_cnt - f0, 1);
      chk(fe_whole == (VECS[v].tail == 0), "R7 whole flag", fe_whole,
          VECS[v].tail == 0);
      chk(miso_oe == 1'b0, "R6 oe low when deselected", miso_oe, 0);
      tx_en = 1'b0;
    end

    // Frame with no bits (R7).
    f0 = fe_cnt;
    frame_open(1'b0);
    frame_close(1'b0);
    chk(fe_cnt == f0 + 1 && fe_whole == 1'b0, "R7 empty frame not whole", fe_whole, 0);

    // Pause in the middle of a read byte (R5).
    frame_open(1'b0);
    bus_byte(8'h0B, q8);
    tx_en = 1'b1; tx_data = 8'hC3;
    for (int i = 7; i >= 4; i--) bus_bit(1'(8'h5A >> i), q8[i]);
    sck = 1'b0; idle(HALF);
    hold_n = 1'b0; idle(HALF);
    chk(miso_oe == 1'b0, "R5 R6 oe low in pause", miso_oe, 1'b0);
    r0 = rx_cnt;
    for (int k = 0; k < 6; k++) begin
      mosi = k[0]; sck = ~sck; idle(HALF);
    end
    sck = 1'b0; idle(HALF);
    chk(rx_cnt == r0, "R5 edges ignored in pause", rx_cnt - r0, 0);
    hold_n = 1'b1; idle(HALF);
    chk(miso_oe == 1'b1, "R5 oe back after pause", miso_oe, 1);
    for (int i = 3; i >= 0; i--) bus_bit(1'(8'h5A >> i), q8[i]);
    chk(rx_cnt == r0 + 1 && rx_last == 8'h5A, "R5 byte resumes at bit position",
        rx_last, 8'h5A);
    chk(q8 == 8'hC3, "R5 transmit resumes at bit position", q8, 8'hC3);
    f0 = fe_cnt;
    frame_close(1'b0);
    chk(fe_cnt == f0 + 1 && fe_whole == 1'b1, "R7 paused frame still whole", fe_whole, 1);
    tx_en = 1'b0;

    // Deselect during a pause on a byte boundary (R8).
    frame_open(1'b0);
    bus_byte(8'h02, q8);
    bus_byte(8'h11, q8);
    sck = 1'b0; idle(HALF);
    hold_n = 1'b0; idle(HALF);
    f0 = fe_cnt;
    cs_n = 1'b1; idle(2*HALF);
    chk(fe_cnt == f0 + 1, "R8 abort gives frame end", fe_cnt - f0, 1);
    chk(fe_whole == 1'b0, "R8 abort not whole", fe_whole, 0);
    hold_n = 1'b1; idle(HALF);
    frame_open(1'b0);
    r0 = rx_cnt;
    bus_byte(8'h9C, q8);
    chk(rx_cnt == r0 + 1 && rx_last == 8'h9C, "R8 fresh frame after abort", rx_last, 8'h9C);
    frame_close(1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule